// File: doc/BRIEF.md
# Windowed Watchdog Timer with Sticky Status

This block supervises a running program. It chains a prescaler and a down counter. Both reload to all-ones. A single write turns the watchdog on and picks a service window at the same time. After that write, no later write can turn it off or change the window. The program must then service the watchdog while the counter value sits at or below the window's upper bound. A service that comes too early raises a reset request. So does a counter that runs out before any service arrives.

The reset request is a one-cycle pulse. In the same cycle it sets a sticky underflow flag, so software can see after restart that the last reset came from the watchdog. A separate input tells the block that the reset controller is applying a watchdog-caused reset. That reload puts the timer back to all-ones and keeps the enable, the window and the flag. Only the asynchronous external/power-on reset clears those bits.

Top module: `wdt_window_top`

## Requirements
- R1: While and after the external reset `rst_n` is low, `wd_rst_req` is 0 and `wd_status` is 0x00.
- R2: The first write with `wr_data[0]`=1 sets the enable (status bit 0) and latches `wr_data[2:1]` as the window select (status bits 2:1). Writes before that with `wr_data[0]`=0, and every write after it, change neither field.
- R3: While enabled and not serviced, the request pulses exactly 2^(PRE_W+CNT_W) cycles after the enabling write or the last reload. The prescaler steps down once per cycle and the counter steps down when the prescaler leaves 0.
- R4: A service is a write with `wr_data[3]`=1 while enabled. If the counter value is at most all-ones >> select, the service reloads both stages to all-ones and raises no request.
- R5: A service while the counter value is above that bound raises the request and reloads both stages.
- R6: The request lasts one cycle per event. The underflow flag (status bit 4) is set in the same cycle and stays set.
- R7: A one-cycle `rst_wdog` reloads both stages. It keeps the enable, the select and the underflow flag, and it raises no request in that cycle.
- R8: The external reset clears the enable, the select and the underflow flag.
- R9: Writes cannot change status bit 4, and status bits 3 and 7:5 always read 0.
- R10: While disabled, service writes raise no request and the timer does not move.
- R11: A service in the cycle where the counter would run out counts as in-window and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous external/power-on reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Bit 0 enable, bits 2:1 window select, bit 3 service; other bits ignored |
| rst_wdog | input | 1 | Watchdog-caused reset being applied by the reset controller |
| wd_rst_req | output | 1 | One-cycle reset request |
| wd_status | output | 8 | Bit 0 enable, bits 2:1 select, bit 4 underflow flag, others 0 |

## Verification
The hardest situations to reach are at the edges of the window. One is a service one count above the bound compared with one exactly at it. The other is a service that lands in the very cycle the counter would run out. The bench reaches them by stepping a cycle-accurate model of elapsed time until it predicts the needed count and phase, and only then issuing the write. Seeded random writes, watchdog reloads and external resets then mix those cases with ordinary traffic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_SEL   = 1;
    localparam int unsigned B_SVC   = 3;
    localparam int unsigned B_UDF   = 4;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
        logic       udf;
        logic       req;
    } wdt_state_t;
endpackage

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    output logic [W-1:0] val,
    output logic         at_zero
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load)
            val_d = '1;
        else if (dec)
            val_d = val_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val_q <= '1;
        else
            val_q <= val_d;
    end

    assign val     = val_q;
    assign at_zero = (val_q == '0);
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [1:0]   sel,
    output logic         too_early
);
    localparam logic [W-1:0] ALL_ONES = '1;
    logic [W-1:0] bound;

    always_comb begin
        bound     = ALL_ONES >> sel;
        too_early = (cnt > bound);
    end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
    import wdt_pkg::*;
#(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rst_wdog,
    output logic             wd_rst_req,
    output logic [REG_W-1:0] wd_status
);
    wdt_state_t   st_d, st_q;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] cnt_val;
    logic         pre_zero, cnt_zero;
    logic         early, svc, runout, fire, reload;
    logic         pre_dec, cnt_dec;

    wdt_downcnt #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .load(reload), .dec(pre_dec),
        .val(pre_val), .at_zero(pre_zero)
    );

    wdt_downcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(reload), .dec(cnt_dec),
        .val(cnt_val), .at_zero(cnt_zero)
    );

    wdt_window #(.W(CNT_W)) u_win (
        .cnt(cnt_val), .sel(st_q.sel), .too_early(early)
    );

    always_comb begin
        st_d    = st_q;
        svc     = wr_en && wr_data[B_SVC] && st_q.en && !rst_wdog;
        runout  = st_q.en && pre_zero && cnt_zero && !svc && !rst_wdog;
        fire    = (svc && early) || runout;
        reload  = rst_wdog || svc || runout;
        pre_dec = st_q.en && !reload;
        cnt_dec = st_q.en && pre_zero && !reload;

        st_d.req = fire;
        st_d.udf = st_q.udf || fire;
        if (!st_q.en && wr_en && wr_data[B_EN] && !rst_wdog) begin
            st_d.en  = 1'b1;
            st_d.sel = wr_data[B_SEL +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        wd_status                = '0;
        wd_status[B_EN]          = st_q.en;
        wd_status[B_SEL +: 2]    = st_q.sel;
        wd_status[B_UDF]         = st_q.udf;
    end

    assign wd_rst_req = st_q.req;
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_wdog,
    input logic       wd_rst_req,
    input logic [7:0] wd_status
);
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wd_status[0] |=> wd_status[0]); // R2
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        wd_status[0] |=> $stable(wd_status[2:1])); // R2
    AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> wd_status[4]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wd_status[4] |=> wd_status[4]); // R7
    AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wdog |=> !wd_rst_req); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_status[0] |=> !wd_rst_req); // R10
endmodule

bind wdt_window_top wdt_window_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rst_wdog(rst_wdog),
    .wd_rst_req(wd_rst_req), .wd_status(wd_status)
);

// File: tb/wdt_window_top_bench.sv
module wdt_window_top_bench;
    localparam int P   = 3;
    localparam int C   = 4;
    localparam int TOT = 1 << (P + C);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rst_wdog = 1'b0;
    logic       wd_rst_req;
    logic [7:0] wd_status;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    bit       m_en, m_udf;
    bit [1:0] m_sel;
    int       m_el;

    wdt_window_top #(.PRE_W(P), .CNT_W(C)) u_wdt_window_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rst_wdog(rst_wdog), .wd_rst_req(wd_rst_req), .wd_status(wd_status)
    );

    always #2 clk = ~clk;

    function automatic int cnt_now();
        return ((TOT - 1) - m_el) >> P;
    endfunction

    function automatic int bound_of(bit [1:0] s);
        return ((1 << C) - 1) >> s;
    endfunction

    function automatic logic [7:0] exp_status();
        return {3'b000, m_udf, 1'b0, m_sel, m_en};
    endfunction

    task automatic compare(string tag, bit exp_req);
        n_cmp++;
        if (wd_rst_req !== exp_req || wd_status !== exp_status()) begin
            n_bad++;
            $display("FAIL %s: req=%0b status=%02h, expected req=%0b status=%02h",
                     tag, wd_rst_req, wd_status, exp_req, exp_status());
        end
    endtask

    task automatic step(bit wr, logic [7:0] d, bit rw, string tag);
        bit svc, early, uf, fire, load, was_en;
        wr_en = wr; wr_data = d; rst_wdog = rw;
        svc    = wr && d[3] && m_en && !rw;
        early  = svc && (cnt_now() > bound_of(m_sel));
        uf     = m_en && !svc && !rw && (m_el == TOT - 1);
        fire   = early || uf;
        load   = rw || svc || uf;
        was_en = m_en;
        @(posedge clk);
        #1;
        m_udf = m_udf || fire;
        if (!m_en && wr && d[0] && !rw) begin
            m_en = 1'b1; m_sel = d[2:1];
        end
        if (load) m_el = 0;
        else if (was_en) m_el = m_el + 1;
        wr_en = 1'b0; wr_data = '0; rst_wdog = 1'b0;
        compare(tag, fire);
    endtask

    task automatic ext_reset();
        rst_n = 1'b0;
        m_en = 0; m_udf = 0; m_sel = 0; m_el = 0;
        @(posedge clk); #1;
        compare("R1 R8 in reset", 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic idle_until_cnt(int target);
        while (cnt_now() != target) step(0, 8'h00, 0, "R3 idle");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                $display("FAIL watchdog: run hung, expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        ext_reset();
        step(0, 8'h00, 0, "R1 after reset");
        // R10: service before enable is ignored
        step(1, 8'h08, 0, "R10 service while disabled");
        repeat (3) step(0, 8'h00, 0, "R10 idle disabled");
        // R2: write with enable bit clear leaves fields alone
        step(1, 8'h06, 0, "R2 write without enable");
        step(1, 8'h05, 0, "R2 enable with select 2");
        step(1, 8'h02, 0, "R2 disable attempt ignored");
        step(1, 8'h07, 0, "R2 reselect attempt ignored");
        // R5: one count above bound
        idle_until_cnt(bound_of(2'd2) + 1);
        step(1, 8'h08, 0, "R5 R6 early service");
        step(0, 8'h00, 0, "R6 request is one pulse");
        // R4: exactly at bound
        idle_until_cnt(bound_of(2'd2));
        step(1, 8'h08, 0, "R4 service at bound");
        // R11: service on the run-out cycle
        while (m_el != TOT - 1) step(0, 8'h00, 0, "R3 idle");
        step(1, 8'h08, 0, "R11 service at run-out");
        // R3: full run-out
        for (int i = 0; i < TOT; i++) step(0, 8'h00, 0, "R3 run-out timing");
        step(0, 8'h00, 0, "R6 pulse ends");
        // R9: read-only bits
        step(1, 8'h10, 0, "R9 write flag bit");
        step(1, 8'hE0, 0, "R9 write unused bits");
        // R7: watchdog-caused reload
        repeat (20) step(0, 8'h00, 0, "R3 idle");
        step(0, 8'h00, 1, "R7 watchdog reload");
        for (int i = 0; i < TOT; i++) step(0, 8'h00, 0, "R7 R3 after reload");
        ext_reset();
        step(0, 8'h00, 0, "R8 fields cleared");
        // random mix
        for (int i = 0; i < 20000; i++) begin
            bit          w, r;
            logic [7:0]  d;
            w = ($urandom % 8) == 0;
            r = ($urandom % 300) == 0;
            d = $urandom;
            if (($urandom % 2500) == 0) ext_reset();
            step(w, d, r, "R2/R3/R4/R5/R7 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule